// File: doc/BRIEF.md
# PCM Time-Slot Assigner with Port Select

This block is the digital slot engine of a telephony PCM serial link. A bit clock carries the serial data, and a frame-sync marker for each direction marks the start of slot 0. The block counts bit-clock periods from that marker across a frame of up to 64 slots of eight bits each. When the count reaches the programmed transmit slot, it shifts out one PCM byte on one of two output ports. While that port drives, its active-low line-driver enable is pulled low. When the count reaches the programmed receive slot, it captures one byte from one of two input ports and presents it with a one-cycle strobe. Having two ports in each direction lets a line card switch traffic between two highways.

The slot, the port and the enable for each direction are loaded through a small serial control port. A command is two bytes long: an opcode that names the direction, then the assignment. A new assignment does not take effect at once. It waits until the second frame start of that direction after the command closes. This keeps a frame already in progress from being cut in half. Everything runs on one core clock. The bit clock, the frame syncs and the control lines are inputs synchronous to that clock, and the block finds their edges by comparing each input with its value in the previous clock cycle.

Top module: `pcm_tsa_top`

## Requirements
- R1: After reset both directions are disabled with slot 0 and port 0: `dx_oe` is 00, `tsx_n` is 11, `dx_data` is 00 and `rx_valid` is 0.
- R2: A bit-clock rising edge that sees a direction's frame sync high, when it was low at the previous rising edge, starts bit 0 of slot 0 for that direction. Each following rising edge advances one bit. Transmit and receive count from their own sync inputs.
- R3: During every bit of the assigned transmit slot, the selected port has `dx_oe` high and carries the byte on `tx_byte`, as latched at that frame's start, MSB first, changing only after bit-clock rising edges. At all other times both ports have `dx_oe` low and `dx_data` low.
- R4: `tsx_n[p]` is low exactly while `dx_oe[p]` is high.
- R5: During the assigned receive slot, the selected `dr` port is sampled on each bit-clock falling edge, MSB first. After the eighth sample, `rx_byte` holds the byte and `rx_valid` is high for one clock cycle. The other port, and all bits outside the slot, are ignored.
- R6: A command is 16 bits on `cdi`, taken MSB first on `cclk` rising edges while `cs_n` is low, and it completes when `cs_n` rises. The first byte 0x29 selects transmit and 0x2A selects receive. In the second byte, bit 7 is the enable, bit 6 the port and bits 5:0 the slot. Any other opcode, or any bit count other than 16, leaves the settings unchanged.
- R7: A completed command takes effect at the second frame start of its direction after `cs_n` rises. The frame that starts first still uses the old settings.
- R8: If a command completes in the same clock cycle as a frame start of its direction, that frame start does not count toward the two.
- R9: With the enable bit clear, that direction neither drives nor captures.
- R10: Bit positions beyond bit 511 of a frame match no slot. Slot 63 (bits 504 to 511) is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | PCM bit clock, sampled by clk |
| fsx | input | 1 | Transmit frame sync |
| fsr | input | 1 | Receive frame sync |
| tx_byte | input | 8 | Byte to send, latched at transmit frame start |
| dx_data | output | 2 | Transmit data for port 0 and port 1 |
| dx_oe | output | 2 | Tri-state enable for each transmit port |
| tsx_n | output | 2 | Active-low line-driver enable for each port |
| dr | input | 2 | Receive data for port 0 and port 1 |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| cs_n | input | 1 | Control chip select, active low |
| cclk | input | 1 | Control shift clock |
| cdi | input | 1 | Control serial data |

## Verification
Two functions can fall in the same core-clock cycle: a command closing on `cs_n` and a frame start on the same direction. The bench provokes this by raising `cs_n` in the same cycle as a bit-clock rising edge that carries the sync pulse. It judges the result by checking, bit by bit, that the old assignment is still served in that frame and in the next one, and that the new assignment is served in the frame after those. Against the same reference model, the bench also runs frames in which receive sync is offset from transmit sync, so that both directions pass their own frame starts at different bit counts.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
  localparam int SLOT_W    = 6;
  localparam int BIT_W     = 3;
  localparam int POS_W     = SLOT_W + BIT_W;
  localparam int BYTE_W    = 1 << BIT_W;
  localparam int CMD_BITS  = 2 * BYTE_W;
  localparam int CNT_W     = $clog2(CMD_BITS + 2);
  localparam int DEFER     = 2;
  localparam int DLY_W     = $clog2(DEFER + 1);
  localparam logic [BYTE_W-1:0] OP_TX = 8'h29;
  localparam logic [BYTE_W-1:0] OP_RX = 8'h2A;

  typedef struct packed {
    logic              en;
    logic              port;
    logic [SLOT_W-1:0] slot;
  } slot_cfg_t;
endpackage

// File: rtl/pcm_tsa_ctrl.sv
module pcm_tsa_ctrl
  import pcm_tsa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      cclk,
  input  logic      cdi,
  output logic      load_tx,
  output logic      load_rx,
  output slot_cfg_t load_cfg
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CMD_BITS + 1);

  logic                cclk_q, cs_q;
  logic [CMD_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                cclk_rise, cs_rise, cmd_ok;

  assign cclk_rise = cclk & ~cclk_q & ~cs_n;
  assign cs_rise   = cs_n & ~cs_q;
  assign cmd_ok    = cs_rise && (cnt_q == CNT_FULL);
  assign load_tx   = cmd_ok && (sh_q[CMD_BITS-1:BYTE_W] == OP_TX);
  assign load_rx   = cmd_ok && (sh_q[CMD_BITS-1:BYTE_W] == OP_RX);
  assign load_cfg  = slot_cfg_t'(sh_q[BYTE_W-1:0]);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (cs_n) begin
      cnt_d = '0;
    end else if (cclk_rise) begin
      sh_d  = {sh_q[CMD_BITS-2:0], cdi};
      cnt_d = (cnt_q == CNT_OVER) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      cclk_q <= cclk;
      cs_q   <= cs_n;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
    end
  end

  p_load_on_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_tx || load_rx) |-> (cs_n && $past(!cs_n)));
endmodule

// File: rtl/pcm_tsa_timebase.sv
module pcm_tsa_timebase
  import pcm_tsa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             fs,
  input  logic             load,
  input  slot_cfg_t        load_cfg,
  output logic             frame_start,
  output logic [POS_W-1:0] pos,
  output logic             in_frame,
  output slot_cfg_t        act_cfg
);
  localparam logic [POS_W-1:0] POS_LAST = '1;
  localparam logic [DLY_W-1:0] DLY_INIT = DLY_W'(DEFER);

  logic             fs_q, fs_d;
  logic [POS_W-1:0] pos_d;
  logic             inf_d;
  slot_cfg_t        act_d, pend_q, pend_d;
  logic [DLY_W-1:0] dly_q, dly_d;

  assign frame_start = bclk_rise & fs & ~fs_q;

  always_comb begin
    fs_d   = bclk_rise ? fs : fs_q;
    pos_d  = pos;
    inf_d  = in_frame;
    act_d  = act_cfg;
    pend_d = pend_q;
    dly_d  = dly_q;
    if (frame_start) begin
      pos_d = '0;
      inf_d = 1'b1;
    end else if (bclk_rise && in_frame) begin
      if (pos == POS_LAST) inf_d = 1'b0;
      else                 pos_d = pos + 1'b1;
    end
    if (load) begin
      pend_d = load_cfg;
      dly_d  = DLY_INIT;
    end else if (frame_start && dly_q != '0) begin
      dly_d = dly_q - 1'b1;
      if (dly_q == DLY_W'(1)) act_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q     <= 1'b0;
      pos      <= '0;
      in_frame <= 1'b0;
      act_cfg  <= '0;
      pend_q   <= '0;
      dly_q    <= '0;
    end else begin
      fs_q     <= fs_d;
      pos      <= pos_d;
      in_frame <= inf_d;
      act_cfg  <= act_d;
      pend_q   <= pend_d;
      dly_q    <= dly_d;
    end
  end

  p_act_only_at_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));
  p_start_bit0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pos == '0 && in_frame));
endmodule

// File: rtl/pcm_tsa_tx.sv
module pcm_tsa_tx
  import pcm_tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_rise,
  input  logic              frame_start,
  input  logic [POS_W-1:0]  pos,
  input  logic              in_frame,
  input  slot_cfg_t         cfg,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [1:0]        dx_data,
  output logic [1:0]        dx_oe
);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] hold_q, hold_d;
  logic              hit, bit_v;

  assign hit   = in_frame && cfg.en && (pos[POS_W-1:BIT_W] == cfg.slot);
  assign bit_v = hold_q[TOP_BIT - pos[BIT_W-1:0]];

  always_comb begin
    hold_d = hold_q;
    if (frame_start) hold_d = tx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign dx_oe[p]   = hit && (cfg.port == 1'(p));
    assign dx_data[p] = dx_oe[p] && bit_v;
  end

  p_one_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dx_oe));
  p_change_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_rise |=> ($stable(dx_oe) && $stable(dx_data)));
endmodule

// File: rtl/pcm_tsa_rx.sv
module pcm_tsa_rx
  import pcm_tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_fall,
  input  logic [POS_W-1:0]  pos,
  input  logic              in_frame,
  input  slot_cfg_t         cfg,
  input  logic [1:0]        dr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] byte_d;
  logic              valid_d, hit, din, take;

  assign hit  = in_frame && cfg.en && (pos[POS_W-1:BIT_W] == cfg.slot);
  assign din  = dr[cfg.port];
  assign take = bclk_fall && hit;

  always_comb begin
    sh_d    = sh_q;
    byte_d  = rx_byte;
    valid_d = 1'b0;
    if (take) begin
      sh_d = {sh_q[BYTE_W-3:0], din};
      if (pos[BIT_W-1:0] == LAST_BIT) begin
        byte_d  = {sh_q, din};
        valid_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      rx_byte  <= byte_d;
      rx_valid <= valid_d;
    end
  end

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_valid_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bclk_fall));
endmodule

// File: rtl/pcm_tsa_top.sv
module pcm_tsa_top
  import pcm_tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk,
  input  logic              fsx,
  input  logic              fsr,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [1:0]        dx_data,
  output logic [1:0]        dx_oe,
  output logic [1:0]        tsx_n,
  input  logic [1:0]        dr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic              cs_n,
  input  logic              cclk,
  input  logic              cdi
);
  logic [1:0]       rst_sync;
  logic             core_rst_n;
  logic             bclk_q, bclk_rise, bclk_fall;
  logic             load_tx, load_rx;
  slot_cfg_t        load_cfg;
  logic [1:0]       fs_v, load_v, start_v, inf_v;
  logic [POS_W-1:0] pos_v [2];
  slot_cfg_t        cfg_v [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) bclk_q <= 1'b0;
    else             bclk_q <= bclk;
  end
  assign bclk_rise = bclk & ~bclk_q;
  assign bclk_fall = ~bclk & bclk_q;

  pcm_tsa_ctrl u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .cs_n(cs_n), .cclk(cclk), .cdi(cdi),
    .load_tx(load_tx), .load_rx(load_rx), .load_cfg(load_cfg)
  );

  assign fs_v   = {fsr, fsx};
  assign load_v = {load_rx, load_tx};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    pcm_tsa_timebase u_tb (
      .clk(clk), .rst_n(core_rst_n), .bclk_rise(bclk_rise), .fs(fs_v[d]),
      .load(load_v[d]), .load_cfg(load_cfg), .frame_start(start_v[d]),
      .pos(pos_v[d]), .in_frame(inf_v[d]), .act_cfg(cfg_v[d])
    );
  end

  pcm_tsa_tx u_tx (
    .clk(clk), .rst_n(core_rst_n), .bclk_rise(bclk_rise),
    .frame_start(start_v[0]), .pos(pos_v[0]), .in_frame(inf_v[0]),
    .cfg(cfg_v[0]), .tx_byte(tx_byte), .dx_data(dx_data), .dx_oe(dx_oe)
  );

  pcm_tsa_rx u_rx (
    .clk(clk), .rst_n(core_rst_n), .bclk_fall(bclk_fall),
    .pos(pos_v[1]), .in_frame(inf_v[1]), .cfg(cfg_v[1]), .dr(dr),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  assign tsx_n = ~dx_oe;

  p_tsx_low_only_driving_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (tsx_n != 2'b11) |-> (dx_oe != 2'b00));
endmodule

// File: tb/pcm_tsa_top_tb.sv
module pcm_tsa_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n, bclk, fsx, fsr, cs_n, cclk, cdi;
  logic [7:0] tx_byte;
  logic [1:0] dr;
  logic [1:0] dx_data, dx_oe, tsx_n;
  logic [7:0] rx_byte;
  logic       rx_valid;

  int checks = 0;
  int errors = 0;

  // reference model: index 0 transmit, 1 receive
  int         m_pos [2];
  bit         m_inf [2];
  bit         m_fsq [2];
  logic [7:0] m_act [2];
  logic [7:0] m_pend[2];
  int         m_dly [2];
  logic [7:0] m_hold;
  logic [7:0] m_rxsh;
  logic [7:0] w_b1, w_b2;
  logic [31:0] pat = 32'h1234_5678;
  int         vcount = 0;
  logic [7:0] vbyte = 8'h00;
  int         oe_bits = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcm_tsa_top u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsx(fsx), .fsr(fsr),
    .tx_byte(tx_byte), .dx_data(dx_data), .dx_oe(dx_oe), .tsx_n(tsx_n),
    .dr(dr), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .cs_n(cs_n), .cclk(cclk), .cdi(cdi)
  );

  always @(negedge clk) if (rx_valid) begin
    vcount <= vcount + 1;
    vbyte  <= rx_byte;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int decode(input logic [7:0] b1, input int nb);
    if (nb != 16) return -1;
    if (b1 == 8'h29) return 0;
    if (b1 == 8'h2A) return 1;
    return -1;
  endfunction

  task automatic model_edge(input bit fs_tx, input bit fs_rx, input int ld);
    bit fsv [2];
    fsv[0] = fs_tx; fsv[1] = fs_rx;
    for (int d = 0; d < 2; d++) begin
      bit start;
      start = fsv[d] && !m_fsq[d];
      m_fsq[d] = fsv[d];
      if (ld == d) begin
        m_pend[d] = w_b2; m_dly[d] = 2;
      end else if (start && m_dly[d] != 0) begin
        if (m_dly[d] == 1) m_act[d] = m_pend[d];
        m_dly[d]--;
      end
      if (start) begin
        m_pos[d] = 0; m_inf[d] = 1'b1;
        if (d == 0) m_hold = tx_byte;
      end else if (m_inf[d]) begin
        if (m_pos[d] == 511) m_inf[d] = 1'b0;
        else m_pos[d]++;
      end
    end
  endtask

  // one bit-clock period of 8 core cycles; close = raise cs_n with the rising edge
  task automatic step(input bit fs_tx, input bit fs_rx, input bit close, input int nb);
    int c0, ld;
    logic [1:0] eoe, edata;
    bit hit, exp_byte;
    @(negedge clk);
    pat = pat * 32'd1103515245 + 32'd12345;
    bclk = 1'b1; fsx = fs_tx; fsr = fs_rx; dr = pat[17:16];
    ld = -1;
    if (close) begin
      cs_n = 1'b1;
      ld = decode(w_b1, nb);
    end
    model_edge(fs_tx, fs_rx, ld);
    c0 = vcount;
    repeat (3) @(negedge clk);
    hit = m_inf[0] && m_act[0][7] && (m_pos[0] / 8 == int'(m_act[0][5:0]));
    eoe = 2'b00;
    if (hit) eoe[m_act[0][6]] = 1'b1;
    edata = eoe & {2{m_hold[7 - (m_pos[0] % 8)]}};
    if (dx_oe != 2'b00) oe_bits++;
    // R3 data and enables, R4 line-driver enables, R9 disabled direction
    chk({dx_oe, dx_data, tsx_n} == {eoe, edata, ~eoe}, "R3/R4/R9",
        $sformatf("tx pos %0d oe,data,tsx", m_pos[0]),
        int'({dx_oe, dx_data, tsx_n}), int'({eoe, edata, ~eoe}));
    @(negedge clk);
    bclk = 1'b0;
    repeat (3) @(negedge clk);
    hit = m_inf[1] && m_act[1][7] && (m_pos[1] / 8 == int'(m_act[1][5:0]));
    exp_byte = 1'b0;
    if (hit) begin
      m_rxsh = {m_rxsh[6:0], dr[m_act[1][6]]};
      exp_byte = (m_pos[1] % 8 == 7);
    end
    // R5 capture from selected port only; R9 no capture when disabled
    chk((vcount - c0) == int'(exp_byte), "R5/R9",
        $sformatf("rx strobes at pos %0d", m_pos[1]), vcount - c0, int'(exp_byte));
    if (exp_byte)
      chk(vbyte == m_rxsh, "R5", "rx byte", int'(vbyte), int'(m_rxsh));
  endtask

  task automatic run_frame(input int nbits, input int rx_off, input logic [7:0] tb);
    tx_byte = tb;
    for (int k = 0; k < nbits; k++) step(k == 0, k == rx_off, 1'b0, 0);
  endtask

  task automatic ctl_shift(input logic [7:0] b1, input logic [7:0] b2, input int nb);
    logic [15:0] w;
    w = {b1, b2};
    w_b1 = b1; w_b2 = b2;
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); cdi = w[15 - i]; cclk = 1'b0;
      @(negedge clk);
      @(negedge clk); cclk = 1'b1;
      @(negedge clk);
    end
    @(negedge clk); cclk = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] b1, input logic [7:0] b2, input int nb);
    ctl_shift(b1, b2, nb);
    @(negedge clk); cs_n = 1'b1;
    model_edge(m_fsq[0], m_fsq[1], decode(b1, nb));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    // R1: reset state
    chk(dx_oe == 2'b00 && dx_data == 2'b00, "R1", "dx after reset",
        int'({dx_oe, dx_data}), 0);
    chk(tsx_n == 2'b11, "R1", "tsx_n after reset", int'(tsx_n), 3);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", int'(rx_valid), 0);
    run_frame(24, 0, 8'hFF);
  endtask

  task automatic t_basic;
    // R6 format, R7 deferral: tx port 0 slot 1, rx port 1 slot 2
    ctl_write(8'h29, 8'b1000_0001, 16);
    ctl_write(8'h2A, 8'b1100_0010, 16);
    run_frame(32, 0, 8'hA5);
    chk(oe_bits == 0, "R7", "no drive in first frame after write", oe_bits, 0);
    oe_bits = 0;
    run_frame(32, 0, 8'h3C);
    chk(oe_bits == 8, "R7", "drive in second frame after write", oe_bits, 8);
    run_frame(32, 0, 8'hC3);
  endtask

  task automatic t_swap_and_offset;
    // R2 separate syncs, R3/R5 port swap
    ctl_write(8'h29, 8'b1100_0000, 16);
    ctl_write(8'h2A, 8'b1000_0011, 16);
    run_frame(40, 5, 8'h81);
    run_frame(40, 5, 8'h7E);
    run_frame(40, 11, 8'h96);
  endtask

  task automatic t_bad_writes;
    // R6: bad opcode and short command are ignored
    ctl_write(8'h33, 8'b1000_0100, 16);
    ctl_write(8'h29, 8'b1000_0100, 15);
    ctl_write(8'h2A, 8'b1100_0001, 17);
    oe_bits = 0;
    run_frame(40, 0, 8'h5A);
    run_frame(40, 0, 8'hE7);
    run_frame(40, 0, 8'h18);
    chk(oe_bits == 24, "R6", "tx still on slot 0 port 1 after bad writes", oe_bits, 24);
  endtask

  task automatic t_coincident;
    // R8: command closes on the same cycle as a transmit frame start
    ctl_shift(8'h29, 8'b1000_0010, 16);
    tx_byte = 8'hB4;
    step(1'b1, 1'b1, 1'b1, 16);
    for (int k = 1; k < 32; k++) step(1'b0, 1'b0, 1'b0, 0);
    run_frame(32, 0, 8'h4B);
    oe_bits = 0;
    run_frame(32, 0, 8'hD2);
    chk(oe_bits == 8, "R8", "new slot served on third frame", oe_bits, 8);
  endtask

  task automatic t_disable;
    // R9: enable bit cleared in both directions
    ctl_write(8'h29, 8'b0100_0000, 16);
    ctl_write(8'h2A, 8'b0000_0001, 16);
    run_frame(24, 0, 8'hFF);
    oe_bits = 0;
    run_frame(24, 0, 8'hFF);
    chk(oe_bits == 0, "R9", "no drive when disabled", oe_bits, 0);
  endtask

  task automatic t_long_frame;
    // R10: slot 63 in a full frame, nothing past bit 511
    ctl_write(8'h29, 8'b1011_1111, 16);
    ctl_write(8'h2A, 8'b1111_1111, 16);
    run_frame(16, 0, 8'h11);
    run_frame(16, 0, 8'h22);
    oe_bits = 0;
    run_frame(520, 0, 8'h69);
    chk(oe_bits == 8, "R10", "slot 63 driven once", oe_bits, 8);
    oe_bits = 0;
    run_frame(40, 0, 8'h69);
    chk(oe_bits == 0, "R10", "slot 63 unreached in short frame", oe_bits, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bclk = 1'b0; fsx = 1'b0; fsr = 1'b0; cs_n = 1'b1;
    cclk = 1'b0; cdi = 1'b0; dr = 2'b00; tx_byte = 8'h00;
    m_hold = 8'h00; m_rxsh = 8'h00; w_b1 = 8'h00; w_b2 = 8'h00;
    for (int d = 0; d < 2; d++) begin
      m_pos[d] = 0; m_inf[d] = 1'b0; m_fsq[d] = 1'b0;
      m_act[d] = 8'h00; m_pend[d] = 8'h00; m_dly[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_swap_and_offset;
    t_bad_writes;
    t_coincident;
    t_disable;
    t_long_frame;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule